// File: doc/BRIEF.md
# Clock frequency accuracy monitor

This block checks whether a target clock runs at the expected rate by comparing it with a reference. Between two accepted edges of the reference it counts prescaled ticks of the target clock. It stores that count and tests it against a programmable lower and upper bound. Clocks are not wired in directly. Each of eight candidate sources arrives as a one-cycle enable pulse on `src_tick`, and everything runs on the single system clock `clk`.

The reference can come from an external pin, which passes through a two-stage synchronizer. It can also come from an internal square wave, made by dividing one of the candidate sources. An optional three-sample majority-free glitch filter can clean the reference before edge detection. Software uses a byte-wide register port. The port has run control, two configuration bytes, an interrupt byte, a read-only status byte, two 16-bit bounds and a 16-bit read-only captured count. Three interrupt lines report a window error, a completed measurement and a counter overflow.

Top module: `clk_accuracy_mon`

## Requirements
- R1: After reset every register reads 0x00 and all three interrupt outputs are low.
- R2: Register offsets are 0 run (bit 0), 1 target config, 2 reference config, 3 interrupt control, 4 status, 6/7 upper bound (low byte/high byte), 8/9 lower bound, 10/11 captured count. Upper and lower bounds read back what was written. Writes to offsets 4, 10 and 11 are ignored. Offset 3 reads back only bits 2:0.
- R3: While run bit 0 is 0, the counter is held at 0, no capture occurs, and no flag is set.
- R4: Target config bits 3:1 pick `src_tick[n]` as the target. Bits 5:4 divide its ticks by 1, 4, 8 or 32 (codes 00..11). The prescaler restarts at every accepted reference edge. The captured count therefore equals the number of divided ticks strictly between two accepted edges: floor((edge spacing − 1)/divisor) with a tick every cycle.
- R5: Target config bits 7:6 select the accepted reference edge: 00 rising, 01 falling, 10 both.
- R6: Reference config bit 0 picks the external pin (0) or the internal reference (1). With the pin, target config bit 0 must be 1, otherwise the pin reads as low. The internal reference divides `src_tick[reference config bits 3:1]` by 32, 128, 1024 or 8192 (bits 5:4 = 00..11).
- R7: Reference config bits 7:6 choose the filter. 00 means off. 01 samples on every divided target tick, 10 on every 4th and 11 on every 16th. A new level is taken only after three equal consecutive samples, so a pulse shorter than three sample periods is rejected.
- R8: The first accepted edge after enabling only arms the counter. Each later accepted edge copies the count into the captured register, restarts the count at 0 and sets the end flag (status bit 1).
- R9: At a capture, the error flag (status bit 0) is set when the captured value is above the upper bound or below the lower bound.
- R10: When the counter wraps from 0xFFFF to 0, the overflow flag (status bit 2) is set.
- R11: Writing 1 to interrupt control bit 4, 5 or 6 clears the error, end or overflow flag. Writing 0 to those bits changes nothing.
- R12: Each interrupt output is high exactly when its flag and its enable (interrupt control bit 0 error, 1 end, 2 overflow) are both 1.
- R13: Target or reference source codes 001 and 111 select no source and give no ticks. Edge code 11 accepts no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| src_tick | input | 8 | One-cycle enable pulses of the eight candidate clocks |
| ref_pin | input | 1 | Asynchronous external reference |
| irq_freq_err | output | 1 | Window error interrupt |
| irq_meas_end | output | 1 | Measurement end interrupt |
| irq_overflow | output | 1 | Counter overflow interrupt |

## Verification
The assertions check the following on every cycle:
- The counter stays cleared while the block is stopped.
- The end and error flags rise only right after an armed, accepted edge.
- The captured register changes only at such an edge.
- The overflow flag rises only after the counter held all ones.
- A prohibited target code freezes the count.

Only the bench scenarios can show the numeric results. These are the captured values for each edge mode, prescaler ratio and reference source, the window decision at its boundaries, and whether the filter rejects short pulses at each sampling rate.

// File: rtl/clk_accuracy_mon.sv
module clk_accuracy_mon #(
  parameter int CNT_W  = 16,
  parameter int NSRC   = 8,
  parameter int RDIV_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  input  logic       ref_pin,
  output logic       irq_freq_err,
  output logic       irq_meas_end,
  output logic       irq_overflow
);

  localparam int SEL_W = $clog2(NSRC);

  logic             run;
  logic             pin_en;
  logic [SEL_W-1:0] tsel;
  logic [1:0]       tdiv, esel;
  logic             ref_int;
  logic [SEL_W-1:0] rsel;
  logic [1:0]       rdiv, fsel;
  logic [2:0]       ie;
  logic             f_err, f_end, f_ovf;
  logic [CNT_W-1:0] upper, lower, cap, cnt;
  logic             armed;

  logic [4:0]        pre_cnt;
  logic [3:0]        fs_cnt;
  logic [RDIV_W-1:0] rdv_cnt;
  logic              ps1, ps2;
  logic [1:0]        smp;
  logic              flt, prev;

  logic wr0, wr1, wr2, wr3;
  assign wr0 = bus_wr && bus_addr == 4'd0;
  assign wr1 = bus_wr && bus_addr == 4'd1;
  assign wr2 = bus_wr && bus_addr == 4'd2;
  assign wr3 = bus_wr && bus_addr == 4'd3;

  // target tick and prescaler
  logic       t_ok, r_ok, tgt_tick, rsrc_tick, cnt_tick;
  logic [4:0] pre_lim;
  assign t_ok      = tsel != SEL_W'(1) && tsel != SEL_W'(7);
  assign r_ok      = rsel != SEL_W'(1) && rsel != SEL_W'(7);
  assign tgt_tick  = t_ok && src_tick[tsel];
  assign rsrc_tick = r_ok && src_tick[rsel];
  always_comb begin
    case (tdiv)
      2'd0:    pre_lim = 5'd0;
      2'd1:    pre_lim = 5'd3;
      2'd2:    pre_lim = 5'd7;
      default: pre_lim = 5'd31;
    endcase
  end
  assign cnt_tick = tgt_tick && pre_cnt == pre_lim;

  // internal reference square wave
  logic int_lvl;
  always_comb begin
    case (rdiv)
      2'd0:    int_lvl = rdv_cnt[4];
      2'd1:    int_lvl = rdv_cnt[6];
      2'd2:    int_lvl = rdv_cnt[9];
      default: int_lvl = rdv_cnt[12];
    endcase
  end

  // reference selection, filter, edge detection
  logic       raw, lvl, samp, edge_ok;
  logic [3:0] fs_lim;
  assign raw = ref_int ? int_lvl : (ps2 & pin_en);
  always_comb begin
    case (fsel)
      2'd2:    fs_lim = 4'd3;
      2'd3:    fs_lim = 4'd15;
      default: fs_lim = 4'd0;
    endcase
  end
  assign samp = cnt_tick && fs_cnt == fs_lim;
  assign lvl  = (fsel == 2'd0) ? raw : flt;
  always_comb begin
    case (esel)
      2'd0:    edge_ok = lvl & ~prev;
      2'd1:    edge_ok = ~lvl & prev;
      2'd2:    edge_ok = lvl ^ prev;
      default: edge_ok = 1'b0;
    endcase
  end

  logic cap_ev, ovf_ev, err_ev;
  assign cap_ev = run && armed && edge_ok;
  assign ovf_ev = run && armed && !edge_ok && cnt_tick && cnt == '1;
  assign err_ev = cap_ev && (cnt > upper || cnt < lower);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      {esel, tdiv, tsel, pin_en} <= '0;
      {fsel, rdiv, rsel, ref_int} <= '0;
      ie <= '0;
      upper <= '0;
      lower <= '0;
    end else begin
      if (wr0) run <= bus_wdata[0];
      if (wr1) {esel, tdiv, tsel, pin_en} <= bus_wdata;
      if (wr2) {fsel, rdiv, rsel, ref_int} <= bus_wdata;
      if (wr3) ie <= bus_wdata[2:0];
      if (bus_wr && bus_addr == 4'd6) upper[7:0]  <= bus_wdata;
      if (bus_wr && bus_addr == 4'd7) upper[15:8] <= bus_wdata;
      if (bus_wr && bus_addr == 4'd8) lower[7:0]  <= bus_wdata;
      if (bus_wr && bus_addr == 4'd9) lower[15:8] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      fs_cnt  <= '0;
      rdv_cnt <= '0;
      ps1 <= 1'b0;
      ps2 <= 1'b0;
      smp <= '0;
      flt <= 1'b0;
      prev <= 1'b0;
    end else begin
      ps1  <= ref_pin;
      ps2  <= ps1;
      prev <= lvl;
      if (rsrc_tick) rdv_cnt <= rdv_cnt + 1'b1;
      if (!run || edge_ok) pre_cnt <= '0;
      else if (tgt_tick) pre_cnt <= (pre_cnt == pre_lim) ? 5'd0 : pre_cnt + 5'd1;
      if (cnt_tick) fs_cnt <= (fs_cnt >= fs_lim) ? 4'd0 : fs_cnt + 4'd1;
      if (samp) begin
        smp <= {smp[0], raw};
        if (smp == {raw, raw}) flt <= raw;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      cap   <= '0;
      f_err <= 1'b0;
      f_end <= 1'b0;
      f_ovf <= 1'b0;
    end else begin
      if (!run) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (edge_ok) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (armed && cnt_tick) begin
        cnt <= cnt + 1'b1;
      end
      if (cap_ev) cap <= cnt;
      if (err_ev) f_err <= 1'b1;
      else if (wr3 && bus_wdata[4]) f_err <= 1'b0;
      if (cap_ev) f_end <= 1'b1;
      else if (wr3 && bus_wdata[5]) f_end <= 1'b0;
      if (ovf_ev) f_ovf <= 1'b1;
      else if (wr3 && bus_wdata[6]) f_ovf <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      4'd0:    bus_rdata = {7'd0, run};
      4'd1:    bus_rdata = {esel, tdiv, tsel, pin_en};
      4'd2:    bus_rdata = {fsel, rdiv, rsel, ref_int};
      4'd3:    bus_rdata = {5'd0, ie};
      4'd4:    bus_rdata = {5'd0, f_ovf, f_end, f_err};
      4'd6:    bus_rdata = upper[7:0];
      4'd7:    bus_rdata = upper[15:8];
      4'd8:    bus_rdata = lower[7:0];
      4'd9:    bus_rdata = lower[15:8];
      4'd10:   bus_rdata = cap[7:0];
      4'd11:   bus_rdata = cap[15:8];
      default: bus_rdata = 8'd0;
    endcase
  end

  assign irq_freq_err = f_err & ie[0];
  assign irq_meas_end = f_end & ie[1];
  assign irq_overflow = f_ovf & ie[2];

  assert_stopped_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !armed));
  assert_end_after_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_end) |-> $past(run && armed && edge_ok));
  assert_cap_only_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap) |-> $past(run && armed && edge_ok));
  assert_err_after_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_err) |-> $past(armed && edge_ok));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_ovf) |-> $past(cnt) == '1);
  assert_prohibited_target_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !t_ok && !edge_ok) |=> $stable(cnt));

endmodule

// File: tb/sim_clk_accuracy_mon.sv
module sim_clk_accuracy_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] src_tick = 8'hFF;
  logic       ref_pin = 1'b0;
  logic       irq_freq_err, irq_meas_end, irq_overflow;

  int checks = 0;
  int errors = 0;
  logic [7:0]  rb;
  logic [15:0] rw;

  always #2 clk = ~clk;

  clk_accuracy_mon u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .ref_pin(ref_pin), .irq_freq_err(irq_freq_err),
    .irq_meas_end(irq_meas_end), .irq_overflow(irq_overflow));

  // {target config, edge spacing, expected count}
  localparam logic [39:0] VEC [6] = '{
    {8'h01, 16'd40,  16'd39},
    {8'h41, 16'd40,  16'd39},
    {8'h81, 16'd40,  16'd19},
    {8'h11, 16'd40,  16'd9},
    {8'h21, 16'd64,  16'd7},
    {8'h31, 16'd200, 16'd6}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      ref_pin = 1'b1;
      repeat (hi) @(negedge clk);
      ref_pin = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic setup(input logic [7:0] c1, input logic [7:0] c2);
    wr(0, 8'h00);
    wr(1, c1);
    wr(2, c2);
    wr(3, 8'h70);
    wr(0, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), rb);
      chk("R1 reset register", rb, 0);
    end
    chk("R1 reset irqs", {irq_freq_err, irq_meas_end, irq_overflow}, 0);

    // R2 map and readback
    wr(6, 8'h34); wr(7, 8'h12); wr(8, 8'hCD); wr(9, 8'hAB);
    rd16(6, rw); chk("R2 upper readback", rw, 16'h1234);
    rd16(8, rw); chk("R2 lower readback", rw, 16'hABCD);
    wr(4, 8'hFF); rd(4, rb); chk("R2 status write ignored", rb, 0);
    wr(10, 8'hFF); rd(10, rb); chk("R2 count write ignored", rb, 0);
    wr(3, 8'h77); rd(3, rb); chk("R2 irq control readback", rb, 8'h07);
    wr(3, 8'h00);
    wr(6, 8'hFF); wr(7, 8'hFF); wr(8, 8'h00); wr(9, 8'h00);

    // R4 R5 vector table
    for (int i = 0; i < 6; i++) begin
      setup(VEC[i][39:32], 8'h00);
      pulses(3, int'(VEC[i][31:16]) / 2, int'(VEC[i][31:16]) / 2);
      repeat (4) @(negedge clk);
      rd16(10, rw);
      chk($sformatf("R4 R5 vector %0d count", i), rw, VEC[i][15:0]);
      rd(4, rb);
      chk($sformatf("R8 vector %0d end flag", i), rb[1], 1);
    end

    // R9 window
    wr(6, 8'd38); wr(7, 0); wr(8, 8'd30); wr(9, 0);
    setup(8'h01, 8'h00); pulses(3, 20, 20);
    rd(4, rb); chk("R9 above upper sets error", rb[0], 1);
    chk("R12 error irq masked", irq_freq_err, 0);
    wr(3, 8'h01);
    chk("R12 error irq enabled", irq_freq_err, 1);
    wr(3, 8'h00);
    wr(6, 8'd40); wr(8, 8'd39);
    setup(8'h01, 8'h00); pulses(3, 20, 20);
    rd(4, rb); chk("R9 inside window no error", rb[0], 0);
    wr(6, 8'd50); wr(8, 8'd40);
    setup(8'h01, 8'h00); pulses(3, 20, 20);
    rd(4, rb); chk("R9 below lower sets error", rb[0], 1);

    // R11 clears
    wr(3, 8'h02);
    chk("R12 end irq enabled", irq_meas_end, 1);
    wr(0, 8'h00);
    wr(3, 8'h02);
    rd(4, rb); chk("R11 writing zero keeps flags", rb, 8'h03);
    wr(3, 8'h12);
    rd(4, rb); chk("R11 clear error only", rb, 8'h02);
    wr(3, 8'h22);
    rd(4, rb); chk("R11 clear end", rb, 8'h00);
    chk("R12 end irq follows flag", irq_meas_end, 0);
    wr(3, 8'h00);
    wr(6, 8'hFF); wr(8, 8'h00);

    // R3 stopped
    setup(8'h01, 8'h00); pulses(3, 20, 20);
    wr(0, 8'h00); wr(3, 8'h70);
    pulses(3, 10, 10);
    rd(4, rb); chk("R3 no flags while stopped", rb, 0);
    rd16(10, rw); chk("R3 count held while stopped", rw, 39);

    // R6 pin gating and internal reference
    setup(8'h00, 8'h00); pulses(3, 20, 20);
    rd(4, rb); chk("R6 pin disabled gives no edge", rb[1], 0);
    setup(8'h00, 8'h01); repeat (200) @(negedge clk);
    rd16(10, rw); chk("R6 internal ratio 32", rw, 31);
    setup(8'h00, 8'h11); repeat (600) @(negedge clk);
    rd16(10, rw); chk("R6 internal ratio 128", rw, 127);

    // R4 R13 target selection
    src_tick = 8'h04;
    setup(8'h05, 8'h00); pulses(3, 20, 20);
    rd16(10, rw); chk("R4 target source 2", rw, 39);
    setup(8'h07, 8'h00); pulses(3, 20, 20);
    rd16(10, rw); chk("R4 unselected source counts 0", rw, 0);
    src_tick = 8'hFF;
    setup(8'h03, 8'h00); pulses(3, 20, 20);
    rd16(10, rw); chk("R13 prohibited target counts 0", rw, 0);
    setup(8'hC1, 8'h00); pulses(3, 20, 20);
    rd(4, rb); chk("R13 edge code 11 no capture", rb[1], 0);

    // R7 filter
    setup(8'h01, 8'h40); pulses(3, 20, 20);
    rd16(10, rw); chk("R7 filtered period", rw, 39);
    setup(8'h01, 8'h40); pulses(3, 2, 40);
    rd(4, rb); chk("R7 short pulse rejected", rb[1], 0);
    setup(8'h01, 8'h00); pulses(3, 2, 40);
    rd16(10, rw); chk("R7 short pulse passes unfiltered", rw, 41);
    setup(8'h01, 8'h80); pulses(3, 8, 40);
    rd(4, rb); chk("R7 slow filter rejects 8 cycles", rb[1], 0);
    setup(8'h01, 8'h40); pulses(3, 8, 40);
    rd(4, rb); chk("R7 fast filter accepts 8 cycles", rb[1], 1);

    // R10 overflow
    setup(8'h01, 8'h00); pulses(1, 5, 5);
    wr(3, 8'h04);
    repeat (65545) @(negedge clk);
    rd(4, rb); chk("R10 overflow flag", rb, 8'h04);
    chk("R12 overflow irq", irq_overflow, 1);
    wr(3, 8'h44);
    rd(4, rb); chk("R11 clear overflow", rb[2], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule